// File: doc/BRIEF.md
# Multiplier Self-Test Controller

This block tests a small two-operand multiplier that sits outside it. When a run is launched it walks through a set of operand pairs, drives each pair onto the multiplier's operand pins for one clock, and compares the product that comes back against a reference product. The reference product is computed internally. At the end of the run it raises a one-cycle completion pulse and holds a verdict that says whether any product was wrong.

Three sweep patterns are available. The full sweep covers every operand pair. Two shorter sweeps keep the top two bits of one operand at zero, which cuts the run to a quarter of the length. A target selector tells the controller which kind of multiplier is attached, and that sets whether the reference product is signed or unsigned. When the controller is idle, a manual path passes operands that the user supplies straight through to the multiplier and returns its product on a separate bus.

Top module: `mult_selftest`

## Requirements
- R1: After reset, busy, done and faulty are 0, and both operand outputs are 0.
- R2: A start seen while idle with target code 1, 2 or 3 launches a run, and busy is 1 from the next clock. A start with target code 0 is ignored.
- R3: Sweep code 0 or 3 (full sweep) applies all 256 operand pairs, one per clock. The pairs come from an incrementing 8-bit counter that starts at 0, with A in the upper nibble and B in the lower nibble.
- R4: Sweep code 1 (reduced A) applies 64 pairs. A[3:2] is 0, A[1:0] is counter bits 5:4, B is counter bits 3:0, and the counter increments from 0.
- R5: Sweep code 2 (reduced B) applies 64 pairs. B[3:2] is 0, B[1:0] is counter bits 1:0, A is counter bits 5:2, and the counter increments from 0.
- R6: For target code 3 the reference product is the two's-complement product of the operands, reduced to 8 bits. For codes 1 and 2 it is the unsigned product. The product input is sampled at the clock edge that ends the cycle in which the pair was driven.
- R7: If any sampled product differs from its reference, faulty is 1 at the end of the run; otherwise faulty is 0. The verdict holds until the next accepted start.
- R8: done pulses for exactly one clock, on the same edge where busy falls. A new run can then be started.
- R9: A start while busy is ignored, and so is any change to the target or sweep inputs during a run, because both are captured when the run is accepted.
- R10: While idle with manual_en set, the operand outputs follow man_a and man_b, and man_prod equals prod_in with no clock delay. Otherwise man_prod is 0, and the operand outputs are 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run |
| target_sel | input | 2 | Attached multiplier: 1, 2 unsigned; 3 signed; 0 invalid |
| sweep_mode | input | 2 | 0/3 full, 1 reduced A, 2 reduced B |
| manual_en | input | 1 | Pass user operands through while idle |
| man_a | input | 4 | Manual operand A |
| man_b | input | 4 | Manual operand B |
| opa | output | 4 | Operand A to the multiplier |
| opb | output | 4 | Operand B to the multiplier |
| prod_in | input | 8 | Product from the multiplier |
| man_prod | output | 8 | Product returned in manual mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| faulty | output | 1 | Verdict of the last run |

## Verification
The bench connects a behavioural multiplier model that can be signed or unsigned, and that can force one product bit stuck at 0 or 1. It targets the following cases:
- A stuck bit 7 under the reduced-A sweep, which no unsigned vector can reach and which must therefore pass. A controller that marks it faulty has a wrong sweep range.
- A correct unsigned model reported against target 3, which must fail. A controller that ignores the signed reference reports it as non-faulty.
- The exact order and count of vectors in each sweep. An off-by-one in the end-of-run condition shows up as a run of 255 or 65 vectors.
- Target code 0 and a start pulse given in the middle of a run with a changed target. A controller that accepts either one either launches a stray run or restarts the current one.

// File: rtl/mult_selftest.sv
module mult_selftest #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   target_sel,
  input  logic [1:0]   sweep_mode,
  input  logic         manual_en,
  input  logic [W-1:0] man_a,
  input  logic [W-1:0] man_b,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb,
  input  logic [2*W-1:0] prod_in,
  output logic [2*W-1:0] man_prod,
  output logic         busy,
  output logic         done,
  output logic         faulty
);
  localparam int P = 2 * W;

  logic         busy_q, done_q, faulty_q, fail_q;
  logic [P-1:0] cnt;
  logic [1:0]   mode_q, sel_q;
  logic [W-1:0] va, vb;
  logic [P-1:0] exp_u, exp_s, exp_p;
  logic         last, mismatch, accept;

  always_comb begin
    case (mode_q)
      2'd1: begin va = {2'b00, cnt[P-3:W]}; vb = cnt[W-1:0]; end
      2'd2: begin va = cnt[P-3:W-2]; vb = {2'b00, cnt[W-3:0]}; end
      default: begin va = cnt[P-1:W]; vb = cnt[W-1:0]; end
    endcase
  end

  assign last = (mode_q == 2'd1 || mode_q == 2'd2) ? (cnt == {2'b00, {(P-2){1'b1}}})
                                                   : (cnt == {P{1'b1}});
  assign exp_u = {{W{1'b0}}, va} * {{W{1'b0}}, vb};
  assign exp_s = {{W{va[W-1]}}, va} * {{W{vb[W-1]}}, vb};
  assign exp_p = (sel_q == 2'd3) ? exp_s : exp_u;
  assign mismatch = prod_in != exp_p;
  assign accept = !busy_q && start && target_sel != 2'd0;

  assign opa = busy_q ? va : (manual_en ? man_a : '0);
  assign opb = busy_q ? vb : (manual_en ? man_b : '0);
  assign man_prod = (!busy_q && manual_en) ? prod_in : '0;
  assign busy = busy_q;
  assign done = done_q;
  assign faulty = faulty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; faulty_q <= 1'b0; fail_q <= 1'b0;
      cnt <= '0; mode_q <= 2'd0; sel_q <= 2'd0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1; cnt <= '0; fail_q <= 1'b0; faulty_q <= 1'b0;
        mode_q <= sweep_mode; sel_q <= target_sel;
      end else if (busy_q) begin
        if (mismatch) fail_q <= 1'b1;
        if (last) begin
          busy_q <= 1'b0; done_q <= 1'b1; faulty_q <= fail_q | mismatch;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_first_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (opa == '0 && opb == '0));
  assert_verdict_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(faulty));
  assert_bad_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && target_sel == 2'd0) |=> !busy);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> !(opa == '0 && opb == '0 && $past(opa) != '0 && !$rose(busy)));
  assert_manual_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> man_prod == '0);
endmodule

// File: tb/sim_mult_selftest.sv
module sim_mult_selftest;
  logic clk = 0, rst_n = 0, start = 0, manual_en = 0;
  logic [1:0] target_sel = 0, sweep_mode = 0;
  logic [3:0] man_a = 0, man_b = 0, opa, opb;
  logic [7:0] prod_in, man_prod;
  logic busy, done, faulty;
  logic model_signed = 0, fault_en = 0, fault_val = 0;
  int fault_bit = 0;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  mult_selftest #(.W(4)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .target_sel(target_sel),
    .sweep_mode(sweep_mode), .manual_en(manual_en), .man_a(man_a), .man_b(man_b),
    .opa(opa), .opb(opb), .prod_in(prod_in), .man_prod(man_prod),
    .busy(busy), .done(done), .faulty(faulty));

  function automatic logic [7:0] gold(input logic [3:0] a, input logic [3:0] b, input logic sgn);
    int ia, ib;
    ia = sgn ? $signed(a) : int'(a);
    ib = sgn ? $signed(b) : int'(b);
    return 8'(ia * ib);
  endfunction

  function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b, input logic sgn,
                                       input logic fe, input int fb, input logic fv);
    logic [7:0] p;
    p = gold(a, b, sgn);
    if (fe) p[fb] = fv;
    return p;
  endfunction

  always_comb prod_in = model(opa, opb, model_signed, fault_en, fault_bit, fault_val);

  function automatic int nvec(input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) ? 64 : 256;
  endfunction

  function automatic logic [7:0] vec(input logic [1:0] m, input int i);
    logic [7:0] c;
    c = 8'(i);
    case (m)
      2'd1: return {2'b00, c[5:4], c[3:0]};
      2'd2: return {c[5:2], 2'b00, c[1:0]};
      default: return c;
    endcase
  endfunction

  function automatic logic exp_bad(input logic [1:0] sel, input logic [1:0] m);
    for (int i = 0; i < nvec(m); i++) begin
      logic [7:0] v;
      v = vec(m, i);
      if (model(v[7:4], v[3:0], model_signed, fault_en, fault_bit, fault_val) != gold(v[7:4], v[3:0], sel == 2'd3))
        return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run(input logic [1:0] sel, input logic [1:0] m, input bit poke, input string req);
    int n;
    bit order_ok;
    logic ebad;
    ebad = exp_bad(sel, m);
    @(negedge clk); target_sel = sel; sweep_mode = m; start = 1;
    @(negedge clk); start = 0;
    check(busy == 1, "R2 busy after start", busy, 1);
    n = 0; order_ok = 1;
    while (busy && n < 300) begin
      if ({opa, opb} != vec(m, n)) order_ok = 0;
      if (poke && n == 5) begin start = 1; target_sel = (sel == 2'd3) ? 2'd1 : 2'd3; sweep_mode = 2'd1; end
      else if (poke && n == 6) start = 0;
      n++;
      @(negedge clk);
    end
    check(order_ok, {req, " vector order"}, 0, 1);
    check(n == nvec(m), {req, " vector count"}, n, nvec(m));
    check(done == 1, "R8 done at end", done, 1);
    check(faulty == ebad, "R7 verdict", faulty, ebad);
    @(negedge clk);
    check(done == 0, "R8 done one cycle", done, 0);
    check(faulty == ebad, "R7 verdict held", faulty, ebad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(busy == 0 && done == 0 && faulty == 0, "R1 reset flags", {busy, done, faulty}, 0);
    check(opa == 0 && opb == 0, "R1 reset operands", {opa, opb}, 0);
    @(negedge clk); rst_n = 1;

    // R3 full sweep, unsigned, clean
    run(2'd1, 2'd0, 0, "R3");
    // R3 full sweep with stuck bit 0 at 1
    fault_en = 1; fault_bit = 0; fault_val = 1;
    run(2'd2, 2'd3, 0, "R3");
    // R4 reduced A, bit 7 stuck at 0 unreachable
    fault_bit = 7; fault_val = 0;
    run(2'd1, 2'd1, 0, "R4");
    // R5 reduced B, bit 3 stuck at 0
    fault_bit = 3; fault_val = 0;
    run(2'd2, 2'd2, 0, "R5");
    fault_en = 0;
    // R6 signed target with signed model passes, unsigned model fails
    model_signed = 1;
    run(2'd3, 2'd0, 0, "R6");
    model_signed = 0;
    run(2'd3, 2'd0, 0, "R6");
    // R9 start while busy ignored
    run(2'd1, 2'd2, 1, "R9");

    // R2 target code 0 ignored
    @(negedge clk); target_sel = 0; start = 1;
    @(negedge clk); start = 0;
    check(busy == 0, "R2 code 0 ignored", busy, 0);

    // R10 manual path
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      manual_en = 1; man_a = 4'($urandom); man_b = 4'($urandom);
      #1;
      check(opa == man_a && opb == man_b, "R10 manual operands", {opa, opb}, {man_a, man_b});
      check(man_prod == gold(man_a, man_b, 0), "R10 manual product", man_prod, gold(man_a, man_b, 0));
    end
    manual_en = 0; #1;
    check(man_prod == 0 && opa == 0, "R10 manual off", man_prod, 0);

    // random runs
    for (int k = 0; k < 6; k++) begin
      model_signed = 1'($urandom);
      fault_en = 1'($urandom);
      fault_bit = $urandom % 8;
      fault_val = 1'($urandom);
      run(2'(1 + $urandom % 3), 2'($urandom), 0, "R6 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule